// File: doc/BRIEF.md
# Frame-End Marker for Pixel Streams

This block sits between an image-processing core and a DMA engine. The core produces a plain stream of 24-bit pixels with valid/ready handshaking but no framing signal. The DMA, however, ends a transfer only when it sees an end-of-packet flag. The block forwards every pixel unchanged onto an AXI4-Stream output. It counts pixels against a frame size of height times width and raises TLAST on the last pixel of each frame.

Height and width come from run-time configuration inputs. Their values are captured when the first pixel of a frame is accepted, so software may reprogram them at any time and the change applies from the next frame. When either dimension is zero, incoming pixels are still accepted, so the upstream core never stalls, but they are discarded and nothing is emitted. A parameter selects the output stage. It is either a registered stage with full throughput and a one-cycle latency, or a purely combinational pass-through.

Top module: `frame_tlast_framer`

## Requirements
- R1: After reset, and after a reset applied in the middle of a frame, m_tvalid is 0, s_ready is 1, and the next accepted pixel is counted as the first pixel of a new frame.
- R2: Every accepted pixel whose frame has non-zero dimensions appears on m_tdata exactly once, with its 24-bit value unchanged and in arrival order.
- R3: With frame size N = height × width, m_tlast is 1 on output pixels N, 2N, 3N and so on of a run of whole frames, and 0 on every other output pixel.
- R4: A 1×1 frame carries m_tlast = 1 on its single pixel, so every pixel of a run of 1×1 frames is marked.
- R5: While m_tvalid is 1 and m_tready is 0, m_tvalid, m_tdata and m_tlast stay unchanged. The frame counter advances only on a completed input handshake.
- R6: Height and width are sampled when the first pixel of a frame is accepted. A change during a frame does not alter that frame's length and takes effect from the following frame.
- R7: When height or width is 0 at the start of a frame, input pixels are accepted (s_ready stays 1 while no output is pending) and no output pixel is produced.
- R8: Once the pixel marked with TLAST has been accepted, the next pixel begins a new frame, and frames may follow back to back with no idle cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_height | input | DIM_W | Frame height in lines, sampled at frame start |
| cfg_width | input | DIM_W | Frame width in pixels, sampled at frame start |
| s_data | input | DATA_W | Incoming pixel |
| s_valid | input | 1 | Incoming pixel is valid |
| s_ready | output | 1 | Block accepts the incoming pixel |
| m_tdata | output | DATA_W | Outgoing pixel (TDATA) |
| m_tvalid | output | 1 | Outgoing pixel is valid (TVALID) |
| m_tready | input | 1 | Downstream accepts the pixel (TREADY) |
| m_tlast | output | 1 | Last pixel of the frame (TLAST) |

## Verification
The checker keeps its own record of frame position, built from cfg_height × cfg_width captured at each frame start. Because of this it assumes that the configuration it samples at the first accepted pixel is the one the block also samples, which means the dimensions must not change in the same cycle as a frame's first handshake. The stimulus meets this condition. Each frame's dimensions are set while the stream is idle or, for the mid-frame change case, only after at least one pixel of the frame has been accepted. The frame-boundary properties apply to the registered output variant and assume an upstream that holds each pixel until it is accepted. The bench drives its valid pattern in that way.

// File: rtl/framer_pkg.sv
package framer_pkg;
   typedef enum logic {
      FR_IDLE = 1'b0,
      FR_BUSY = 1'b1
   } frame_state_e;
endpackage

// File: rtl/framer_dims.sv
module framer_dims #(
   parameter int DIM_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             capture,
   input  logic             in_frame,
   input  logic [DIM_W-1:0] cfg_h,
   input  logic [DIM_W-1:0] cfg_w,
   output logic [DIM_W-1:0] eff_h,
   output logic [DIM_W-1:0] eff_w
);
   logic [DIM_W-1:0] h_q, w_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         h_q <= '0;
         w_q <= '0;
      end else if (capture) begin
         h_q <= cfg_h;
         w_q <= cfg_w;
      end
   end

   // Live configuration governs the first pixel; held copy governs the rest.
   assign eff_h = in_frame ? h_q : cfg_h;
   assign eff_w = in_frame ? w_q : cfg_w;
endmodule

// File: rtl/framer_counter.sv
module framer_counter
   import framer_pkg::*;
#(
   parameter int DIM_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv,
   input  logic [DIM_W-1:0] eff_h,
   input  logic [DIM_W-1:0] eff_w,
   output logic             in_frame,
   output logic             last_px,
   output logic             zero_dim
);
   localparam logic [DIM_W-1:0] ONE = DIM_W'(1);

   frame_state_e     state_q;
   logic [DIM_W-1:0] col_q, row_q;
   logic             col_end, row_end;

   assign zero_dim = (eff_w == '0) || (eff_h == '0);
   assign col_end  = (col_q == (eff_w - ONE));
   assign row_end  = (row_q == (eff_h - ONE));
   assign last_px  = col_end && row_end && !zero_dim;
   assign in_frame = (state_q == FR_BUSY);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= FR_IDLE;
         col_q   <= '0;
         row_q   <= '0;
      end else if (adv && !zero_dim) begin
         if (last_px) begin
            state_q <= FR_IDLE;
            col_q   <= '0;
            row_q   <= '0;
         end else if (col_end) begin
            state_q <= FR_BUSY;
            col_q   <= '0;
            row_q   <= row_q + ONE;
         end else begin
            state_q <= FR_BUSY;
            col_q   <= col_q + ONE;
         end
      end
   end
endmodule

// File: rtl/framer_outreg.sv
module framer_outreg #(
   parameter int DATA_W  = 24,
   parameter int REG_OUT = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] s_data,
   input  logic              s_valid,
   output logic              s_ready,
   input  logic              drop,
   input  logic              last_in,
   output logic [DATA_W-1:0] m_tdata,
   output logic              m_tvalid,
   input  logic              m_tready,
   output logic              m_tlast
);
   generate
      if (REG_OUT != 0) begin : g_reg
         logic [DATA_W-1:0] data_q;
         logic              valid_q, last_q;

         assign s_ready = !valid_q || m_tready;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               valid_q <= 1'b0;
               last_q  <= 1'b0;
               data_q  <= '0;
            end else if (s_valid && s_ready) begin
               valid_q <= !drop;
               if (!drop) begin
                  data_q <= s_data;
                  last_q <= last_in;
               end
            end else if (m_tready) begin
               valid_q <= 1'b0;
            end
         end

         assign m_tdata  = data_q;
         assign m_tvalid = valid_q;
         assign m_tlast  = last_q;
      end else begin : g_pass
         assign s_ready  = drop || m_tready;
         assign m_tvalid = s_valid && !drop;
         assign m_tdata  = s_data;
         assign m_tlast  = last_in;
      end
   endgenerate
endmodule

// File: rtl/frame_tlast_framer.sv
module frame_tlast_framer #(
   parameter int DATA_W  = 24,
   parameter int DIM_W   = 12,
   parameter int REG_OUT = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DIM_W-1:0]  cfg_height,
   input  logic [DIM_W-1:0]  cfg_width,
   input  logic [DATA_W-1:0] s_data,
   input  logic              s_valid,
   output logic              s_ready,
   output logic [DATA_W-1:0] m_tdata,
   output logic              m_tvalid,
   input  logic              m_tready,
   output logic              m_tlast
);
   generate
      if (DATA_W < 1) begin : g_bad_data
         $error("frame_tlast_framer: DATA_W must be at least 1");
      end
      if (DIM_W < 1 || DIM_W > 16) begin : g_bad_dim
         $error("frame_tlast_framer: DIM_W must lie in 1..16");
      end
      if (REG_OUT < 0 || REG_OUT > 1) begin : g_bad_reg
         $error("frame_tlast_framer: REG_OUT must be 0 or 1");
      end
   endgenerate

   logic             in_hs, in_frame, last_px, zero_dim;
   logic [DIM_W-1:0] eff_h, eff_w;

   assign in_hs = s_valid && s_ready;

   framer_dims #(.DIM_W(DIM_W)) u_dims (
      .clk      (clk),
      .rst_n    (rst_n),
      .capture  (in_hs && !in_frame),
      .in_frame (in_frame),
      .cfg_h    (cfg_height),
      .cfg_w    (cfg_width),
      .eff_h    (eff_h),
      .eff_w    (eff_w)
   );

   framer_counter #(.DIM_W(DIM_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .adv      (in_hs),
      .eff_h    (eff_h),
      .eff_w    (eff_w),
      .in_frame (in_frame),
      .last_px  (last_px),
      .zero_dim (zero_dim)
   );

   framer_outreg #(.DATA_W(DATA_W), .REG_OUT(REG_OUT)) u_out (
      .clk      (clk),
      .rst_n    (rst_n),
      .s_data   (s_data),
      .s_valid  (s_valid),
      .s_ready  (s_ready),
      .drop     (zero_dim),
      .last_in  (last_px),
      .m_tdata  (m_tdata),
      .m_tvalid (m_tvalid),
      .m_tready (m_tready),
      .m_tlast  (m_tlast)
   );
endmodule

// File: rtl/framer_checker.sv
module framer_checker #(
   parameter int DATA_W  = 24,
   parameter int DIM_W   = 12,
   parameter int REG_OUT = 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic [DIM_W-1:0]  cfg_height,
   input logic [DIM_W-1:0]  cfg_width,
   input logic              s_valid,
   input logic              s_ready,
   input logic [DATA_W-1:0] m_tdata,
   input logic              m_tvalid,
   input logic              m_tready,
   input logic              m_tlast
);
   localparam int PW = 2 * DIM_W;

   logic          hs, ck_busy, exp_last_q;
   logic [PW-1:0] start_size, ck_size, ck_cnt;

   assign hs         = s_valid && s_ready;
   assign start_size = PW'(cfg_height) * PW'(cfg_width);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ck_busy    <= 1'b0;
         ck_size    <= '0;
         ck_cnt     <= '0;
         exp_last_q <= 1'b0;
      end else if (hs) begin
         if (!ck_busy) begin
            if (start_size == PW'(1)) begin
               exp_last_q <= 1'b1;
            end else if (start_size != '0) begin
               exp_last_q <= 1'b0;
               ck_busy    <= 1'b1;
               ck_size    <= start_size;
               ck_cnt     <= PW'(1);
            end
         end else if (ck_cnt + PW'(1) == ck_size) begin
            exp_last_q <= 1'b1;
            ck_busy    <= 1'b0;
         end else begin
            exp_last_q <= 1'b0;
            ck_cnt     <= ck_cnt + PW'(1);
         end
      end
   end

   generate
      if (REG_OUT != 0) begin : g_props
         AST_HOLD_WHEN_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
            (m_tvalid && !m_tready) |=> (m_tvalid && $stable(m_tdata) && $stable(m_tlast))); // R5
         AST_RISE_NEEDS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(m_tvalid) |-> $past(s_valid && s_ready)); // R2
         AST_LAST_AT_FRAME_END: assert property (@(posedge clk) disable iff (!rst_n)
            (hs && (ck_busy || start_size != '0)) |=> (m_tvalid && (m_tlast == exp_last_q))); // R3
         AST_SINGLE_PIXEL_LAST: assert property (@(posedge clk) disable iff (!rst_n)
            (hs && !ck_busy && start_size == PW'(1)) |=> m_tlast); // R4
         AST_ZERO_DIM_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
            (hs && !ck_busy && start_size == '0) |=> !m_tvalid); // R7
      end
   endgenerate
endmodule

bind frame_tlast_framer framer_checker #(
   .DATA_W (DATA_W),
   .DIM_W  (DIM_W),
   .REG_OUT(REG_OUT)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cfg_height (cfg_height),
   .cfg_width  (cfg_width),
   .s_valid    (s_valid),
   .s_ready    (s_ready),
   .m_tdata    (m_tdata),
   .m_tvalid   (m_tvalid),
   .m_tready   (m_tready),
   .m_tlast    (m_tlast)
);

// File: tb/frame_tlast_framer_test.sv
`timescale 1ns/1ps
module frame_tlast_framer_test;
   localparam int DATA_W = 24;
   localparam int DIM_W  = 12;

   // each row: height, width, valid pattern, ready pattern
   localparam logic [31:0] VEC [0:7] = '{
      {8'd1, 8'd1, 8'hFF, 8'hFF},
      {8'd2, 8'd3, 8'hFF, 8'hFF},
      {8'd2, 8'd3, 8'hB7, 8'h5A},
      {8'd3, 8'd1, 8'hFF, 8'h33},
      {8'd1, 8'd5, 8'h6D, 8'hFF},
      {8'd4, 8'd4, 8'hFF, 8'hC9},
      {8'd0, 8'd3, 8'hFF, 8'hFF},
      {8'd2, 8'd0, 8'hAA, 8'h0F}
   };

   logic              clk = 1'b0;
   logic              rst_n;
   logic [DIM_W-1:0]  cfg_height, cfg_width;
   logic [DATA_W-1:0] s_data;
   logic              s_valid, s_ready;
   logic [DATA_W-1:0] m_tdata;
   logic              m_tvalid, m_tready, m_tlast;

   int checks = 0;
   int failures = 0;
   int seq = 0;
   bit done = 0;

   logic [DATA_W-1:0] exp_d [0:63];
   logic              exp_l [0:63];

   always #5 clk = ~clk;

   frame_tlast_framer #(.DATA_W(DATA_W), .DIM_W(DIM_W), .REG_OUT(1)) uut (
      .clk(clk), .rst_n(rst_n), .cfg_height(cfg_height), .cfg_width(cfg_width),
      .s_data(s_data), .s_valid(s_valid), .s_ready(s_ready),
      .m_tdata(m_tdata), .m_tvalid(m_tvalid), .m_tready(m_tready), .m_tlast(m_tlast)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic run_frame(input int h, input int w, input int npix,
                            input logic [7:0] vp, input logic [7:0] rp,
                            input int chg_at, input int nh, input int nw);
      int sent = 0, head = 0, tail = 0, cyc = 0, fsz;
      bit prev_stall = 0;
      logic [DATA_W-1:0] pd = '0;
      logic pl = 1'b0;
      fsz = h * w;
      cfg_height = DIM_W'(h);
      cfg_width  = DIM_W'(w);
      while ((sent < npix || head != tail) && cyc < 3000) begin
         if (prev_stall)
            chk(m_tvalid && m_tdata == pd && m_tlast == pl, "R5 output held under stall",
                {7'd0, m_tvalid, m_tdata}, {8'd1, pd});
         if (sent == chg_at) begin
            cfg_height = DIM_W'(nh);
            cfg_width  = DIM_W'(nw);
         end
         m_tready = rp[cyc % 8];
         s_valid  = (sent < npix) && vp[(cyc * 3) % 8];
         s_data   = {8'hC3, seq[15:0]};
         #1;
         if (m_tvalid && m_tready) begin
            if (head == tail) begin
               chk(1'b0, "R7 unexpected output pixel", {8'd0, m_tdata}, 32'd0);
            end else begin
               chk(m_tdata == exp_d[head], "R2 pixel data", {8'd0, m_tdata}, {8'd0, exp_d[head]});
               chk(m_tlast == exp_l[head], (fsz == 1) ? "R4 single pixel last" : "R3 last position",
                   {31'd0, m_tlast}, {31'd0, exp_l[head]});
               head++;
            end
         end
         if (s_valid && s_ready) begin
            if (fsz != 0) begin
               exp_d[tail] = s_data;
               exp_l[tail] = ((sent + 1) % fsz) == 0;
               tail++;
            end
            sent++;
            seq++;
         end
         prev_stall = m_tvalid && !m_tready;
         pd = m_tdata;
         pl = m_tlast;
         @(posedge clk);
         @(negedge clk);
         cyc++;
      end
      s_valid = 1'b0;
      chk(sent == npix && head == tail, (fsz == 0) ? "R7 zero-size input drained" : "R8 frames completed",
          32'(sent * 256 + head), 32'(npix * 256 + tail));
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0;
      cfg_height = '0;
      cfg_width = '0;
      s_data = '0;
      s_valid = 1'b0;
      m_tready = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(!m_tvalid && s_ready && !m_tlast, "R1 reset state",
          {29'd0, m_tvalid, s_ready, m_tlast}, 32'h2);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < 8; i++) begin
         int h, w;
         h = int'(VEC[i][31:24]);
         w = int'(VEC[i][23:16]);
         run_frame(h, w, (h * w == 0) ? 5 : 2 * h * w, VEC[i][15:8], VEC[i][7:0], -1, 0, 0);
      end

      // R6: mid-frame change to 1x1 does not shorten the 2x3 frame
      run_frame(2, 3, 6, 8'hFF, 8'hFF, 2, 1, 1);
      run_frame(1, 1, 3, 8'hFF, 8'h5A, -1, 0, 0);
      // R6: mid-frame change to zero size does not stop the current frame
      run_frame(1, 4, 4, 8'hFF, 8'hFF, 1, 0, 0);

      // R1: reset in the middle of a 2x3 frame, then a 1x2 frame starts clean
      cfg_height = DIM_W'(2);
      cfg_width  = DIM_W'(3);
      m_tready = 1'b1;
      s_valid  = 1'b1;
      repeat (3) begin
         s_data = {8'hC3, seq[15:0]};
         seq++;
         @(posedge clk);
         @(negedge clk);
      end
      s_valid = 1'b0;
      rst_n = 1'b0;
      @(posedge clk);
      @(negedge clk);
      chk(!m_tvalid && s_ready, "R1 mid-frame reset clears output",
          {30'd0, m_tvalid, s_ready}, 32'h1);
      rst_n = 1'b1;
      @(negedge clk);
      run_frame(1, 2, 4, 8'hFF, 8'hFF, -1, 0, 0);

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule